// File: doc/BRIEF.md
# PC-style physical address map router

This block takes one byte access per cycle on a 32-bit physical address and works out which part of a PC-style memory layout it lands in. There are seven areas: conventional RAM at the bottom, the display window, the adapter/option ROM window, the firmware ROM just below 1 MiB, extended RAM above 1 MiB, an empty hole, and the device window at the top of the space. For each access the block reports a one-hot area select and the byte offset inside that area. It also returns read data and flags any write that the target area refuses.

Small behavioural stores sit behind the writable areas, and each is indexed by the low bits of the area offset. The two ROM areas return contents that are computed from the offset, so they need no stored table. The end of extended RAM follows the amount of RAM fitted and the start of the device window is fixed by the platform, so both are parameters. Every response comes out of registers two clock edges after the request.

Top module: `pcmap_top`

## Requirements
- R1: Addresses 0x00000000 to 0x0009FFFF select conventional RAM: rsp_sel bit 0, and the offset equals the address.
- R2: Addresses 0x000A0000 to 0x000BFFFF select the display window: rsp_sel bit 1, with offset = address − 0xA0000.
- R3: Addresses 0x000C0000 to 0x000EFFFF select the option ROM window: rsp_sel bit 2, with offset = address − 0xC0000. Reads return off[7:0] ^ off[15:8] ^ 0xC3. Writes set rsp_dropped.
- R4: Addresses 0x000F0000 to 0x000FFFFF select the firmware ROM: rsp_sel bit 3, with offset = address − 0xF0000. Reads return off[7:0] ^ off[15:8] ^ 0x3C. The reset fetch address 0x000FFFF0 decodes here and reads 0x33.
- R5: A write to the firmware ROM sets rsp_dropped and leaves its contents unchanged, so a later read of the same address returns the same computed byte.
- R6: Addresses from 0x00100000 to EXT_TOP−1 select extended RAM: rsp_sel bit 4, with offset = address − 0x100000. The default EXT_TOP is 0x01000000.
- R7: Addresses from EXT_TOP to DEV_BASE−1 select the hole: rsp_sel bit 5, with offset = address − EXT_TOP. Reads return GAP_FILL (0xFF). Writes set rsp_dropped.
- R8: Addresses from DEV_BASE to 0xFFFFFFFF select the device window: rsp_sel bit 6, with offset = address − DEV_BASE. The default DEV_BASE is 0xFE000000.
- R9: The conventional RAM, display, extended RAM and device areas store written bytes. A later read of the same address returns the byte written. Writes to these areas leave rsp_dropped low.
- R10: While rsp_valid is high, exactly one rsp_sel bit is set. While rsp_valid is low, rsp_sel is zero.
- R11: The response to a request arrives exactly two rising edges after the request is presented. Back-to-back requests produce back-to-back responses in order, and rsp_valid is high for one cycle per request.
- R12: While rst is high, every response output is zero, and a request presented during reset produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | An access is presented this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Physical byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Response present |
| rsp_is_write | output | 1 | The response belongs to a write |
| rsp_sel | output | 7 | One-hot area select (bit order as in R1–R8) |
| rsp_offset | output | 32 | Byte offset within the selected area |
| rsp_rdata | output | 8 | Read byte (zero for writes) |
| rsp_dropped | output | 1 | The write was refused by a read-only or empty area |

## Verification
Every result (select, offset, read byte and drop flag) is due on the second rising edge after the request is driven: one edge registers the decode and the store read, and the next edge registers the output mux. The bench drives each request at a falling edge and samples two falling edges later, midway between the clock edges. For the back-to-back case it samples on each following falling edge, one response per cycle, and then checks that rsp_valid falls. Read-after-write checks issue the read only after the write's response has been seen, so the write edge has already passed.

// File: rtl/pcmap_pkg.sv
package pcmap_pkg;
  localparam int NREG = 7;

  typedef enum logic [2:0] {
    RG_LOW    = 3'd0,
    RG_VIDEO  = 3'd1,
    RG_EXPROM = 3'd2,
    RG_BIOS   = 3'd3,
    RG_EXT    = 3'd4,
    RG_GAP    = 3'd5,
    RG_DEV    = 3'd6
  } region_e;

  localparam logic [31:0] VIDEO_BASE  = 32'h000A_0000;
  localparam logic [31:0] EXPROM_BASE = 32'h000C_0000;
  localparam logic [31:0] BIOS_BASE   = 32'h000F_0000;
  localparam logic [31:0] EXT_BASE    = 32'h0010_0000;

  localparam int NRAM = 4;

  // maps store slot to the area it backs
  function automatic region_e ram_slot_region(input int slot);
    case (slot)
      0:       return RG_LOW;
      1:       return RG_VIDEO;
      2:       return RG_EXT;
      default: return RG_DEV;
    endcase
  endfunction

  function automatic logic region_writable(input region_e r);
    return (r == RG_LOW) || (r == RG_VIDEO) || (r == RG_EXT) || (r == RG_DEV);
  endfunction
endpackage

// File: rtl/pcmap_decode.sv
module pcmap_decode
  import pcmap_pkg::*;
#(
  parameter logic [31:0] EXT_TOP  = 32'h0100_0000,
  parameter logic [31:0] DEV_BASE = 32'hFE00_0000
) (
  input  logic [31:0] addr,
  output region_e     region,
  output logic [31:0] offset
);
  logic [31:0] base;

  always_comb begin
    if (addr < VIDEO_BASE)       region = RG_LOW;
    else if (addr < EXPROM_BASE) region = RG_VIDEO;
    else if (addr < BIOS_BASE)   region = RG_EXPROM;
    else if (addr < EXT_BASE)    region = RG_BIOS;
    else if (addr < EXT_TOP)     region = RG_EXT;
    else if (addr < DEV_BASE)    region = RG_GAP;
    else                         region = RG_DEV;
  end

  always_comb begin
    case (region)
      RG_LOW:    base = 32'h0;
      RG_VIDEO:  base = VIDEO_BASE;
      RG_EXPROM: base = EXPROM_BASE;
      RG_BIOS:   base = BIOS_BASE;
      RG_EXT:    base = EXT_BASE;
      RG_GAP:    base = EXT_TOP;
      default:   base = DEV_BASE;
    endcase
    offset = addr - base;
  end
endmodule

// File: rtl/pcmap_ram.sv
module pcmap_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // plain synchronous port, no reset on the array: maps to block RAM
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    q <= mem[addr];
  end
endmodule

// File: rtl/pcmap_rom.sv
module pcmap_rom #(
  parameter int FLAVOR = 0   // 0: firmware pattern, 1: option ROM pattern
) (
  input  logic        clk,
  input  logic [15:0] off,
  output logic [7:0]  q
);
  generate
    if (FLAVOR == 0) begin : g_fw
      always_ff @(posedge clk) q <= off[7:0] ^ off[15:8] ^ 8'h3C;
    end else begin : g_opt
      always_ff @(posedge clk) q <= off[7:0] ^ off[15:8] ^ 8'hC3;
    end
  endgenerate
endmodule

// File: rtl/pcmap_top.sv
module pcmap_top
  import pcmap_pkg::*;
#(
  parameter logic [31:0] EXT_TOP  = 32'h0100_0000,
  parameter logic [31:0] DEV_BASE = 32'hFE00_0000,
  parameter int          MEM_AW   = 8,
  parameter logic [7:0]  GAP_FILL = 8'hFF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [31:0]     req_addr,
  input  logic [7:0]      req_wdata,
  output logic            rsp_valid,
  output logic            rsp_is_write,
  output logic [NREG-1:0] rsp_sel,
  output logic [31:0]     rsp_offset,
  output logic [7:0]      rsp_rdata,
  output logic            rsp_dropped
);
  region_e     dec_region;
  logic [31:0] dec_off;

  pcmap_decode #(.EXT_TOP(EXT_TOP), .DEV_BASE(DEV_BASE)) u_dec (
    .addr(req_addr), .region(dec_region), .offset(dec_off)
  );

  // stage 1: decode and store read
  logic        s1_valid, s1_write, s1_drop;
  region_e     s1_region;
  logic [31:0] s1_off;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_write  <= 1'b0;
      s1_drop   <= 1'b0;
      s1_region <= RG_LOW;
      s1_off    <= '0;
    end else begin
      s1_valid  <= req_valid;
      s1_write  <= req_write;
      s1_drop   <= req_valid && req_write && !region_writable(dec_region);
      s1_region <= dec_region;
      s1_off    <= dec_off;
    end
  end

  logic [7:0] ram_q [NRAM];

  generate
    for (genvar i = 0; i < NRAM; i++) begin : g_ram
      logic we_i;
      assign we_i = !rst && req_valid && req_write && (dec_region == ram_slot_region(i));
      pcmap_ram #(.AW(MEM_AW), .DW(8)) u_ram (
        .clk(clk), .we(we_i), .addr(dec_off[MEM_AW-1:0]),
        .wdata(req_wdata), .q(ram_q[i])
      );
    end
  endgenerate

  logic [7:0] fw_q, opt_q;
  pcmap_rom #(.FLAVOR(0)) u_fw  (.clk(clk), .off(dec_off[15:0]), .q(fw_q));
  pcmap_rom #(.FLAVOR(1)) u_opt (.clk(clk), .off(dec_off[15:0]), .q(opt_q));

  // stage 2: output mux and registers
  logic [7:0] rd_mux;
  always_comb begin
    case (s1_region)
      RG_LOW:    rd_mux = ram_q[0];
      RG_VIDEO:  rd_mux = ram_q[1];
      RG_EXT:    rd_mux = ram_q[2];
      RG_DEV:    rd_mux = ram_q[3];
      RG_BIOS:   rd_mux = fw_q;
      RG_EXPROM: rd_mux = opt_q;
      default:   rd_mux = GAP_FILL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_is_write <= 1'b0;
      rsp_sel      <= '0;
      rsp_offset   <= '0;
      rsp_rdata    <= '0;
      rsp_dropped  <= 1'b0;
    end else begin
      rsp_valid    <= s1_valid;
      rsp_is_write <= s1_valid && s1_write;
      rsp_sel      <= s1_valid ? (NREG'(1) << s1_region) : '0;
      rsp_offset   <= s1_valid ? s1_off : '0;
      rsp_rdata    <= (s1_valid && !s1_write) ? rd_mux : 8'h00;
      rsp_dropped  <= s1_valid && s1_drop;
    end
  end

  // ---------------- assertions ----------------
  assert_sel_onehot_R10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $onehot(rsp_sel));

  assert_sel_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (rsp_sel == '0));

  assert_latency_R11: assert property (@(posedge clk) disable iff (rst)
    s1_valid |=> rsp_valid);

  assert_no_spurious_R11: assert property (@(posedge clk) disable iff (rst)
    !s1_valid |=> !rsp_valid);

  assert_reset_vector_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_addr == 32'h000F_FFF0) |=> (s1_region == RG_BIOS));

  assert_rom_write_drop_R5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_is_write && (rsp_sel[RG_BIOS] || rsp_sel[RG_EXPROM] || rsp_sel[RG_GAP]))
      |-> rsp_dropped);

  assert_ram_keeps_write_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_dropped |-> !(rsp_sel[RG_LOW] || rsp_sel[RG_VIDEO] || rsp_sel[RG_EXT] || rsp_sel[RG_DEV]));

  assert_gap_fill_R7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_is_write && rsp_sel[RG_GAP]) |-> (rsp_rdata == GAP_FILL));
endmodule

// File: tb/tb_pcmap_top.sv
module tb_pcmap_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] EXT_TOP  = 32'h0100_0000;
  localparam logic [31:0] DEV_BASE = 32'hFE00_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid, rsp_is_write, rsp_dropped;
  logic [6:0]  rsp_sel;
  logic [31:0] rsp_offset;
  logic [7:0]  rsp_rdata;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcmap_top #(.EXT_TOP(EXT_TOP), .DEV_BASE(DEV_BASE), .MEM_AW(8), .GAP_FILL(8'hFF)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_is_write(rsp_is_write), .rsp_sel(rsp_sel), .rsp_offset(rsp_offset),
    .rsp_rdata(rsp_rdata), .rsp_dropped(rsp_dropped)
  );

  // {address, expected area index}
  localparam logic [34:0] VEC [15] = '{
    {32'h0000_0000, 3'd0}, {32'h0009_FFFF, 3'd0},
    {32'h000A_0000, 3'd1}, {32'h000B_FFFF, 3'd1},
    {32'h000C_0000, 3'd2}, {32'h000E_FFFF, 3'd2},
    {32'h000F_0000, 3'd3}, {32'h000F_FFF0, 3'd3}, {32'h000F_FFFF, 3'd3},
    {32'h0010_0000, 3'd4}, {32'h00FF_FFFF, 3'd4},
    {32'h0100_0000, 3'd5}, {32'hFDFF_FFFF, 3'd5},
    {32'hFE00_0000, 3'd6}, {32'hFFFF_FFFF, 3'd6}
  };

  function automatic logic [31:0] area_base(input int r);
    case (r)
      0: return 32'h0;
      1: return 32'h000A_0000;
      2: return 32'h000C_0000;
      3: return 32'h000F_0000;
      4: return 32'h0010_0000;
      5: return EXT_TOP;
      default: return DEV_BASE;
    endcase
  endfunction

  function automatic string area_req(input int r);
    case (r)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R6";
      5: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [7:0] fw_byte(input logic [31:0] off);
    return off[7:0] ^ off[15:8] ^ 8'h3C;
  endfunction

  function automatic logic [7:0] opt_byte(input logic [31:0] off);
    return off[7:0] ^ off[15:8] ^ 8'hC3;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one access; returns at the falling edge where the response is registered
  task automatic access(input logic wr, input logic [31:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R12: request during reset produces no response
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h000F_FFF0;
    @(negedge clk); @(negedge clk); @(negedge clk);
    check("R12", "rsp_valid in reset", {31'b0, rsp_valid}, 32'd0);
    check("R12", "rsp_sel in reset", {25'b0, rsp_sel}, 32'd0);
    check("R12", "rsp_rdata in reset", {24'b0, rsp_rdata}, 32'd0);
    check("R12", "rsp_dropped in reset", {31'b0, rsp_dropped}, 32'd0);
    req_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R12", "idle after reset", {31'b0, rsp_valid}, 32'd0);

    // boundary table walk: R10 plus the area requirement
    for (int i = 0; i < 15; i++) begin
      logic [31:0] a;
      int r;
      logic [31:0] off;
      a = VEC[i][34:3];
      r = int'(VEC[i][2:0]);
      off = a - area_base(r);
      access(1'b0, a, 8'h00);
      check("R11", "rsp_valid", {31'b0, rsp_valid}, 32'd1);
      check("R10", "sel", {25'b0, rsp_sel}, 32'(7'd1 << r));
      check(area_req(r), "offset", rsp_offset, off);
      if (r == 2) check("R3", "option ROM data", {24'b0, rsp_rdata}, {24'b0, opt_byte(off)});
      if (r == 3) check("R4", "firmware data", {24'b0, rsp_rdata}, {24'b0, fw_byte(off)});
      if (r == 5) check("R7", "hole data", {24'b0, rsp_rdata}, 32'hFF);
    end

    // reset vector value
    access(1'b0, 32'h000F_FFF0, 8'h00);
    check("R4", "reset vector byte", {24'b0, rsp_rdata}, 32'h33);

    // R9: writable areas keep data
    access(1'b1, 32'h0000_0123, 8'hAB);
    check("R9", "low write not dropped", {31'b0, rsp_dropped}, 32'd0);
    access(1'b1, 32'h000A_0010, 8'hCD);
    access(1'b1, 32'h0010_0055, 8'hEF);
    access(1'b1, 32'hFE00_0007, 8'h5A);
    check("R9", "device write not dropped", {31'b0, rsp_dropped}, 32'd0);
    access(1'b0, 32'h0000_0123, 8'h00);
    check("R9", "low readback", {24'b0, rsp_rdata}, 32'hAB);
    access(1'b0, 32'h000A_0010, 8'h00);
    check("R9", "display readback", {24'b0, rsp_rdata}, 32'hCD);
    access(1'b0, 32'h0010_0055, 8'h00);
    check("R9", "extended readback", {24'b0, rsp_rdata}, 32'hEF);
    access(1'b0, 32'hFE00_0007, 8'h00);
    check("R9", "device readback", {24'b0, rsp_rdata}, 32'h5A);

    // R5: firmware write refused, contents unchanged
    access(1'b1, 32'h000F_FFF0, 8'h00);
    check("R5", "firmware write dropped", {31'b0, rsp_dropped}, 32'd1);
    check("R5", "write has no read data", {24'b0, rsp_rdata}, 32'd0);
    access(1'b0, 32'h000F_FFF0, 8'h00);
    check("R5", "firmware unchanged", {24'b0, rsp_rdata}, 32'h33);

    // R3: option ROM write refused
    access(1'b1, 32'h000C_1234, 8'h77);
    check("R3", "option write dropped", {31'b0, rsp_dropped}, 32'd1);
    access(1'b0, 32'h000C_1234, 8'h00);
    check("R3", "option unchanged", {24'b0, rsp_rdata}, {24'b0, opt_byte(32'h1234)});

    // R7: hole write refused
    access(1'b1, 32'h2000_0000, 8'h12);
    check("R7", "hole write dropped", {31'b0, rsp_dropped}, 32'd1);
    access(1'b0, 32'h2000_0000, 8'h00);
    check("R7", "hole read", {24'b0, rsp_rdata}, 32'hFF);

    // R11: back-to-back responses in order
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h000F_0001;
    @(negedge clk);
    req_addr = 32'h3000_0000;
    @(negedge clk);
    req_addr = 32'h000C_0002;
    check("R11", "pipe 1 sel", {25'b0, rsp_sel}, 32'h08);
    check("R11", "pipe 1 data", {24'b0, rsp_rdata}, {24'b0, fw_byte(32'h1)});
    @(negedge clk);
    req_valid = 1'b0;
    check("R11", "pipe 2 sel", {25'b0, rsp_sel}, 32'h20);
    check("R11", "pipe 2 offset", rsp_offset, 32'h3000_0000 - EXT_TOP);
    @(negedge clk);
    check("R11", "pipe 3 sel", {25'b0, rsp_sel}, 32'h04);
    check("R11", "pipe 3 data", {24'b0, rsp_rdata}, {24'b0, opt_byte(32'h2)});
    @(negedge clk);
    check("R11", "valid drops", {31'b0, rsp_valid}, 32'd0);
    check("R10", "idle sel zero", {25'b0, rsp_sel}, 32'd0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule